// File: doc/BRIEF.md
# Timekeeping RAM Bus Port

This block is a clock-synchronous model of the asynchronous static-RAM style port on a battery-backed memory whose uppermost locations act as clock registers. It takes active-low chip enable, write enable and output enable, an address, an input data word, and an access-inhibit line from a power supervisor. It returns a read data word and a separate output-enable for the data bus. All analog timing is expressed as whole clock edges.

The block decides when a write is in progress. A write exists only while chip enable and write enable are both low and inhibit is low. Each write is checked for address stability, data setup, data hold and recovery from the previous write. A write that breaks any of these rules is dropped and raises a sticky error flag. A read drives the bus only under a narrow set of conditions. The bus turns off a parameterised number of edges after write enable falls.

The eight highest addresses are the clock-register window. Within it, the day register carries a battery-health bit that software can read but cannot write.

Top module: `tkram_port`

## Requirements
- R1: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0 and `inhibit`=0, outside a recovery window, and with `we_n`=1 or `we_n` low for fewer than T_WEZ edges. While `dout_en` is 1, `dout` is the word stored at `addr`.
- R2: A write is in progress on each rising edge where `ce_n`=0, `we_n`=0 and `inhibit`=0. It begins on the edge where the later of the two enables is first seen low. After a clean cycle, the stored word is the `din` value sampled on the last active edge.
- R3: A write is kept only if `din` was unchanged over at least T_SU consecutive active edges ending at the last active edge. Otherwise it is discarded and `err` becomes 1.
- R4: After the first edge with either enable high, `din` must still equal the captured word on that edge and on the following edges, T_HD edges in all. Otherwise the write is discarded and `err` becomes 1.
- R5: If `addr` changes on any active edge of a write, the write is discarded and `err` becomes 1.
- R6: A write that begins fewer than T_REC+1 edges after the end edge of the previous write is discarded and sets `err`. A read in that window leaves `dout_en` at 0. T_HD must not exceed T_REC.
- R7: With `ce_n`=0 and `oe_n`=0, the bus keeps driving read data after `we_n` falls. It stops once `we_n` has been sampled low on T_WEZ rising edges.
- R8: With `inhibit`=1, `dout_en` is 0 and any write in progress or pending hold is dropped without setting `err`.
- R9: The day register sits at address 2^ADDR_W-8+4, in the top-eight clock window. On a read, its bit 7 equals `batt_ok`, and writes never change that bit. Bits 6:0 and every other address behave as plain storage.
- R10: Reset clears every stored word to 0 and `err` to 0. Once set, `err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| inhibit | input | 1 | Power-fail access block, active high |
| batt_ok | input | 1 | Battery health, 1 = good |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Data bus drive enable |
| err | output | 1 | Sticky timing-violation flag |

## Verification
The assertions assume that inputs change only between rising edges. They also assume that `inhibit` is low during the cycle that follows reset, so that a commit can be compared with the inhibit value on the edge before it. The bench changes every input on the falling edge and releases reset with `inhibit` low. It keeps every legal write well inside the setup, hold and recovery windows. Each violation case breaks exactly one rule by one edge, and reset is applied before the next case so that the sticky flag starts from 0 each time.

// File: rtl/tkram_pkg.sv
package tkram_pkg;

    localparam int CLK_REG_COUNT = 8;
    localparam int DAY_OFFSET    = 4;
    localparam int BATT_BIT      = 7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACT,
        PH_HOLD
    } wr_phase_e;

    typedef struct packed {
        logic addr_moved;
        logic too_soon;
    } wr_viol_t;

    function automatic int day_index(input int aw);
        return (1 << aw) - CLK_REG_COUNT + DAY_OFFSET;
    endfunction

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/tkram_cycle.sv
module tkram_cycle
    import tkram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int T_SU   = 2,
    parameter int T_HD   = 2,
    parameter int T_REC  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              inhibit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data,
    output logic              rec_busy,
    output logic              err
);

    localparam int SUW = cnt_width(T_SU);
    localparam int HDW = cnt_width(T_HD);
    localparam int RCW = cnt_width(T_REC);

    wr_phase_e         phase;
    wr_viol_t          viol;
    logic [SUW-1:0]    su_cnt;
    logic [HDW-1:0]    hold_left;
    logic [RCW-1:0]    rec_cnt;
    logic              wr_act;
    logic              setup_ok;

    assign wr_act   = !ce_n && !we_n && !inhibit;
    assign setup_ok = (T_SU == 0) || (int'(su_cnt) >= T_SU);
    assign rec_busy = (rec_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            viol      <= '0;
            su_cnt    <= '0;
            hold_left <= '0;
            rec_cnt   <= '0;
            c_addr    <= '0;
            c_data    <= '0;
            commit    <= 1'b0;
            err       <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (rec_cnt != '0) begin
                rec_cnt <= rec_cnt - 1'b1;
            end
            case (phase)
                PH_IDLE: begin
                    if (wr_act) begin
                        phase           <= PH_ACT;
                        c_addr          <= addr;
                        c_data          <= din;
                        su_cnt          <= SUW'(1);
                        viol.addr_moved <= 1'b0;
                        viol.too_soon   <= (rec_cnt != '0);
                    end
                end
                PH_ACT: begin
                    if (wr_act) begin
                        if (addr != c_addr) begin
                            viol.addr_moved <= 1'b1;
                        end
                        if (din != c_data) begin
                            c_data <= din;
                            su_cnt <= SUW'(1);
                        end else if (int'(su_cnt) < T_SU) begin
                            su_cnt <= su_cnt + 1'b1;
                        end
                    end else begin
                        rec_cnt <= RCW'(T_REC);
                        phase   <= PH_IDLE;
                        if (inhibit) begin
                            phase <= PH_IDLE;
                        end else if (viol.addr_moved || viol.too_soon || !setup_ok) begin
                            err <= 1'b1;
                        end else if (T_HD == 0) begin
                            commit <= 1'b1;
                        end else if (din != c_data) begin
                            err <= 1'b1;
                        end else if (T_HD == 1) begin
                            commit <= 1'b1;
                        end else begin
                            phase     <= PH_HOLD;
                            hold_left <= HDW'(T_HD - 1);
                        end
                    end
                end
                PH_HOLD: begin
                    if (inhibit) begin
                        phase <= PH_IDLE;
                    end else if (din != c_data) begin
                        err   <= 1'b1;
                        phase <= PH_IDLE;
                    end else if (hold_left == HDW'(1)) begin
                        commit <= 1'b1;
                        phase  <= PH_IDLE;
                    end else begin
                        hold_left <= hold_left - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tkram_store.sv
module tkram_store
    import tkram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_data,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              batt_ok,
    output logic [DATA_W-1:0] rdata
);

    localparam int                DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] DAY_ADDR = ADDR_W'(day_index(ADDR_W));

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wr_word;

    always_comb begin
        wr_word = c_data;
        if (c_addr == DAY_ADDR) begin
            wr_word[BATT_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (commit) begin
            mem[c_addr] <= wr_word;
        end
    end

    always_comb begin
        rdata = mem[raddr];
        if (raddr == DAY_ADDR) begin
            rdata[BATT_BIT] = batt_ok;
        end
    end

endmodule

// File: rtl/tkram_bus.sv
module tkram_bus
    import tkram_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int T_WEZ  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              inhibit,
    input  logic              rec_busy,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int WZW = cnt_width(T_WEZ);

    logic [WZW-1:0] we_lo;
    logic           we_window;

    always_ff @(posedge clk) begin
        if (rst || we_n) begin
            we_lo <= '0;
        end else if (int'(we_lo) < T_WEZ) begin
            we_lo <= we_lo + 1'b1;
        end
    end

    assign we_window = we_n || (int'(we_lo) < T_WEZ);
    assign dout_en   = !ce_n && !oe_n && !inhibit && !rec_busy && we_window;
    assign dout      = dout_en ? rdata : '0;

endmodule

// File: rtl/tkram_port.sv
module tkram_port
    import tkram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int T_SU   = 2,
    parameter int T_HD   = 2,
    parameter int T_REC  = 3,
    parameter int T_WEZ  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              inhibit,
    input  logic              batt_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              err
);

    logic              commit;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;
    logic              rec_busy;
    logic [DATA_W-1:0] rdata;

    tkram_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .T_SU(T_SU), .T_HD(T_HD), .T_REC(T_REC)
    ) u_cycle (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .inhibit(inhibit),
        .addr(addr), .din(din), .commit(commit), .c_addr(c_addr),
        .c_data(c_data), .rec_busy(rec_busy), .err(err)
    );

    tkram_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst(rst), .commit(commit), .c_addr(c_addr),
        .c_data(c_data), .raddr(addr), .batt_ok(batt_ok), .rdata(rdata)
    );

    tkram_bus #(
        .DATA_W(DATA_W), .T_WEZ(T_WEZ)
    ) u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .inhibit(inhibit), .rec_busy(rec_busy), .rdata(rdata),
        .dout(dout), .dout_en(dout_en)
    );

endmodule

// File: rtl/tkram_port_chk.sv
module tkram_port_chk
    import tkram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int T_WEZ  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              inhibit,
    input logic              batt_ok,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              err,
    input logic              commit
);

    localparam logic [ADDR_W-1:0] DAY_ADDR = ADDR_W'(day_index(ADDR_W));

    int we_edges;

    always_ff @(posedge clk) begin
        if (rst || we_n) begin
            we_edges <= 0;
        end else if (we_edges < T_WEZ) begin
            we_edges <= we_edges + 1;
        end
    end

    a_r1_drive_needs_enables: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!ce_n && !oe_n));

    a_r7_bus_off_after_we: assert property (@(posedge clk) disable iff (rst)
        (!we_n && we_edges >= T_WEZ) |-> !dout_en);

    a_r8_inhibit_no_drive: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> !dout_en);

    a_r8_no_commit_when_inhibited: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(inhibit));

    a_r9_battery_bit: assert property (@(posedge clk) disable iff (rst)
        (dout_en && addr == DAY_ADDR) |-> (dout[BATT_BIT] == batt_ok));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

bind tkram_port tkram_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WEZ(T_WEZ)
) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .inhibit(inhibit), .batt_ok(batt_ok), .addr(addr), .dout(dout),
    .dout_en(dout_en), .err(err), .commit(commit)
);

// File: tb/tkram_port_tb.sv
module tkram_port_tb;

    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int TSU   = 2;
    localparam int THD   = 2;
    localparam int TREC  = 3;
    localparam int TWEZ  = 2;
    localparam int DEPTH = 1 << AW;
    localparam int DAY   = DEPTH - 8 + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic          inhibit = 1'b0, batt_ok = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    tkram_port #(
        .ADDR_W(AW), .DATA_W(DW), .T_SU(TSU), .T_HD(THD),
        .T_REC(TREC), .T_WEZ(TWEZ)
    ) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .inhibit(inhibit), .batt_ok(batt_ok), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; inhibit = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
    endtask

    function automatic logic [DW-1:0] expect_rd(input int a);
        logic [DW-1:0] v;
        v = model[a];
        if (a == DAY) v[7] = batt_ok;
        return v;
    endfunction

    task automatic wr(input int a, input logic [DW-1:0] d, input int act,
                      input int hold, input int idle);
        @(negedge clk);
        addr = AW'(a); din = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (act) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (hold) @(negedge clk);
        din = ~d;
        repeat (idle) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d, output logic en);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_check(input string req, input int a);
        logic [DW-1:0] d;
        logic en;
        rd(a, d, en);
        check(req, {31'd0, en}, 32'd1);
        check(req, {24'd0, d}, {24'd0, expect_rd(a)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic en;

        do_reset();
        // R10: reset state
        check("R10 err after reset", {31'd0, err}, 32'd0);
        check("R1 idle bus", {31'd0, dout_en}, 32'd0);
        rd_check("R10 cleared word", 0);

        // R2 R9: sweep every address
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] v;
            v = DW'(a * 37 + 5);
            wr(a, v, 3, THD, TREC + 1);
            model[a] = v;
            if (a == DAY) model[a][7] = 1'b0;
        end
        for (int a = 0; a < DEPTH; a++) rd_check("R2 R9 sweep readback", a);
        check("R2 no error in sweep", {31'd0, err}, 32'd0);

        // R9: battery flag follows batt_ok, write of ones and zeros
        wr(DAY, 8'hFF, 3, THD, TREC + 1); model[DAY] = 8'h7F;
        batt_ok = 1'b0;
        rd_check("R9 day bit7 low battery", DAY);
        wr(DAY, 8'h00, 3, THD, TREC + 1); model[DAY] = 8'h00;
        batt_ok = 1'b1;
        rd_check("R9 day bit7 good battery", DAY);

        // R2 R1: chip enable first, write enable later; oe high means no drive
        @(negedge clk);
        addr = 5'd3; din = 8'hA5; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        #1 check("R1 oe high no drive", {31'd0, dout_en}, 32'd0);
        repeat (3) @(negedge clk);
        we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (THD) @(negedge clk);
        ce_n = 1'b1; din = 8'h00;
        repeat (TREC + 1) @(negedge clk);
        model[3] = 8'hA5;
        rd_check("R2 later assertion write", 3);

        // R3: data change mid-write, final word kept
        @(negedge clk);
        addr = 5'd4; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        din = 8'h22;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (THD) @(negedge clk);
        repeat (TREC + 1) @(negedge clk);
        model[4] = 8'h22;
        rd_check("R3 last stable data", 4);
        check("R3 no error", {31'd0, err}, 32'd0);

        // R3: setup too short after change
        @(negedge clk);
        addr = 5'd5; din = 8'h33; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        din = 8'h44;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (THD) @(negedge clk);
        repeat (TREC + 1) @(negedge clk);
        check("R3 setup short err", {31'd0, err}, 32'd1);
        rd_check("R3 setup short discarded", 5);
        // R10: err stays set
        repeat (10) @(negedge clk);
        check("R10 err sticky", {31'd0, err}, 32'd1);

        do_reset();
        wr(6, 8'h5A, 1, THD, TREC + 1);
        check("R3 single edge err", {31'd0, err}, 32'd1);
        rd_check("R3 single edge discarded", 6);

        // R4: hold too short
        do_reset();
        wr(7, 8'h6B, 3, THD - 1, TREC + 1);
        check("R4 hold err", {31'd0, err}, 32'd1);
        rd_check("R4 hold discarded", 7);

        // R5: address moves
        do_reset();
        @(negedge clk);
        addr = 5'd8; din = 8'h77; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = 5'd9;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (THD + TREC + 1) @(negedge clk);
        check("R5 addr move err", {31'd0, err}, 32'd1);
        rd_check("R5 first addr untouched", 8);
        rd_check("R5 second addr untouched", 9);

        // R6: read inside recovery window is off
        do_reset();
        wr(10, 8'h9C, 3, THD, 0);
        model[10] = 8'h9C;
        rd(10, d, en);
        check("R6 read in recovery no drive", {31'd0, en}, 32'd0);
        repeat (TREC + 1) @(negedge clk);
        rd_check("R6 read after recovery", 10);

        // R6: write too soon after previous one
        wr(11, 8'h12, 3, THD, 0);
        model[11] = 8'h12;
        wr(12, 8'h34, 3, THD, TREC + 1);
        check("R6 recovery err", {31'd0, err}, 32'd1);
        rd_check("R6 first write kept", 11);
        rd_check("R6 second write dropped", 12);

        // R7: bus turns off after T_WEZ edges of we low
        do_reset();
        wr(13, 8'hC3, 3, THD, TREC + 1); model[13] = 8'hC3;
        @(negedge clk);
        addr = 5'd13; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 check("R7 read before we", {24'd0, dout}, 32'hC3);
        @(negedge clk);
        we_n = 1'b0; din = 8'h3C;
        #1 check("R7 drive at 0 edges", {31'd0, dout_en}, 32'd1);
        @(negedge clk);
        #1 check("R7 drive at 1 edge", {31'd0, dout_en}, 32'd1);
        @(negedge clk);
        #1 check("R7 off at T_WEZ edges", {31'd0, dout_en}, 32'd0);
        we_n = 1'b1; oe_n = 1'b1;
        repeat (THD) @(negedge clk);
        ce_n = 1'b1;
        repeat (TREC + 1) @(negedge clk);
        model[13] = 8'h3C;
        rd_check("R7 write during read stored", 13);

        // R8: inhibit blocks read and write without error
        @(negedge clk);
        inhibit = 1'b1;
        rd(13, d, en);
        check("R8 no drive inhibited", {31'd0, en}, 32'd0);
        wr(14, 8'hEE, 3, THD, TREC + 1);
        @(negedge clk);
        inhibit = 1'b0;
        check("R8 no err from inhibit", {31'd0, err}, 32'd0);
        rd_check("R8 write blocked", 14);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule